// File: doc/BRIEF.md
# Dual-Convention Stack Pointer Unit

This block owns a stack pointer and carries out byte and word pushes and pops over a byte-wide synchronous memory port. A mode input chooses between two stack conventions. In the free-slot convention the pointer names the next unused byte. In the occupied-slot convention it names the byte written most recently. A word moves as two byte accesses on consecutive cycles. Its high byte sits at the lower address, so the value is the lower-address byte shifted up by one byte, ORed with the upper-address byte.

Requests arrive on a valid/ready stream (`req_valid`, `req_ready`) that carries the direction, the width and the push data. A request is taken only on a clock edge where both `req_valid` and `req_ready` are high. While an operation runs, `req_ready` stays low and `busy` is high. A request presented during that time is not recorded, so a requester that wants it taken must hold it until `req_ready` returns. A pointer load (`ld_en`, `ld_val`) is a plain control input. When the block is idle the load wins over a request in the same cycle, and a load applied while busy is dropped. Results have no back-pressure. `done` pulses for one cycle, and in that cycle `pop_data` and the updated pointer are valid.

The memory port is synchronous. A read issued in one cycle returns its byte on `mem_rdata` in the next cycle.

Top module: `stkptr_unit`

## Requirements
- R1: After reset, `sp` equals the parameter RESET_SP (default 16'h00FF), and `busy`, `done`, `mem_we` and `mem_re` are 0.
- R2: When idle, `ld_en` high loads `ld_val` into `sp` at the next edge. During that cycle `req_ready` is 0, so a request presented with the load is not taken.
- R3: Free-slot mode (`stk_mode`=0), byte push: writes `req_data[7:0]` at SP, and the new SP is SP-1.
- R4: Free-slot mode, word push: writes `req_data[15:8]` at SP-1, then `req_data[7:0]` at SP, and the new SP is SP-2.
- R5: Free-slot mode, pop: a byte pop reads SP+1, gives `pop_data` = {8'h00, byte} and sets SP+1. A word pop reads the high byte at SP+1 and the low byte at SP+2, and sets SP+2.
- R6: Occupied-slot mode (`stk_mode`=1), push: the new SP is SP-size (size 1 or 2), and the data goes at the new SP. For a word, the high byte goes at the new SP and the low byte at the new SP+1.
- R7: Occupied-slot mode, pop: reads at SP (a word's high byte at SP, its low byte at SP+1), and the new SP is SP+size.
- R8: Counting the accepting edge as edge 0, `done` is high for exactly one cycle after edge 1 (byte push), edge 2 (word push, byte pop) or edge 3 (word pop). `sp` changes at that same edge and at no other edge, apart from loads.
- R9: From the accepting edge until the completing edge, `busy` is 1 and `req_ready` is 0. Requests and loads presented then change neither `sp` nor memory.
- R10: All pointer and address arithmetic wraps modulo 2^16.
- R11: `stk_mode` is sampled at acceptance. At most one of `mem_we` and `mem_re` is high in any cycle, and neither is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stk_mode | input | 1 | 0 = free-slot convention, 1 = occupied-slot convention |
| ld_en | input | 1 | Load the pointer from `ld_val` (taken only when idle) |
| ld_val | input | AW | Pointer load value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_pop | input | 1 | 1 = pop, 0 = push |
| req_word | input | 1 | 1 = word (two bytes), 0 = byte |
| req_data | input | 2*DW | Push data; a byte push uses the low byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 2*DW | Pop result, valid while `done` is high |
| sp | output | AW | Current stack pointer |
| mem_addr | output | AW | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Memory write byte |
| mem_rdata | input | DW | Memory read byte, one cycle after `mem_re` |

## Verification
The bench builds the block with AW=16, DW=8 and RESET_SP=16'h00FF. The 16-bit pointer width makes the wrap cases reachable: word pushes and pops that straddle 16'hFFFF and 16'h0000, and byte operations that cross the same boundary. The bench's 256-byte memory model, indexed by the low address byte, keeps the two bytes of a straddling word apart, so each byte's placement can be read back exactly.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_TAIL = 2'd2
  } stk_state_e;

  typedef enum logic {
    CONV_FREE_SLOT = 1'b0,
    CONV_LAST_USED = 1'b1
  } stk_conv_e;
endpackage

// File: rtl/stk_addr_calc.sv
// First-byte address and post-operation pointer for one request.
module stk_addr_calc
  import stk_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          conv,
  input  logic          pop,
  input  logic          word,
  input  logic [AW-1:0] sp_cur,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] next_sp
);
  logic [AW-1:0] size_v;
  logic [AW-1:0] size_m1;

  always_comb begin
    size_v  = word ? AW'(2) : AW'(1);
    size_m1 = word ? AW'(1) : AW'(0);
    if (conv == CONV_LAST_USED) begin
      if (pop) begin
        first_addr = sp_cur;
        next_sp    = sp_cur + size_v;
      end else begin
        first_addr = sp_cur - size_v;
        next_sp    = sp_cur - size_v;
      end
    end else begin
      if (pop) begin
        first_addr = sp_cur + AW'(1);
        next_sp    = sp_cur + size_v;
      end else begin
        first_addr = sp_cur - size_m1;
        next_sp    = sp_cur - size_v;
      end
    end
  end
endmodule

// File: rtl/stk_sp_reg.sv
// Pointer register: a load or a completion commit, never both at once.
module stk_sp_reg #(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] RESET_SP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          commit,
  input  logic [AW-1:0] commit_val,
  output logic [AW-1:0] sp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      sp_q <= RESET_SP;
    else if (load)   sp_q <= load_val;
    else if (commit) sp_q <= commit_val;
  end
endmodule

// File: rtl/stk_seq.sv
// Byte sequencer: one memory access per cycle, then a tail cycle for reads.
module stk_seq
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_pop,
  input  logic            start_word,
  input  logic [2*DW-1:0] start_data,
  input  logic [AW-1:0]   start_addr,
  input  logic [AW-1:0]   start_nsp,
  output logic            busy,
  output logic            done,
  output logic            commit,
  output logic [AW-1:0]   commit_sp,
  output logic [2*DW-1:0] pop_data,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);
  stk_state_e      state_q;
  logic            beat_q;
  logic            pop_q;
  logic            word_q;
  logic [AW-1:0]   base_q;
  logic [AW-1:0]   nsp_q;
  logic [2*DW-1:0] wbuf_q;
  logic [DW-1:0]   hi_q;
  logic [2*DW-1:0] pdata_q;
  logic            done_q;
  logic            in_xfer;
  logic            at_last;

  always_comb begin
    in_xfer   = (state_q == ST_XFER);
    at_last   = (beat_q == word_q);
    busy      = (state_q != ST_IDLE);
    mem_addr  = base_q + AW'(beat_q);
    mem_we    = in_xfer && !pop_q;
    mem_re    = in_xfer && pop_q;
    mem_wdata = (word_q && !beat_q) ? wbuf_q[2*DW-1:DW] : wbuf_q[DW-1:0];
    commit    = (in_xfer && at_last && !pop_q) || (state_q == ST_TAIL);
    commit_sp = nsp_q;
    done      = done_q;
    pop_data  = pdata_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= 1'b0;
      pop_q   <= 1'b0;
      word_q  <= 1'b0;
      base_q  <= '0;
      nsp_q   <= '0;
      wbuf_q  <= '0;
      hi_q    <= '0;
      pdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= commit;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_XFER;
            beat_q  <= 1'b0;
            pop_q   <= start_pop;
            word_q  <= start_word;
            base_q  <= start_addr;
            nsp_q   <= start_nsp;
            wbuf_q  <= start_data;
          end
        end
        ST_XFER: begin
          // second beat of a word read sees the high byte returning
          if (pop_q && beat_q) hi_q <= mem_rdata;
          if (at_last) state_q <= pop_q ? ST_TAIL : ST_IDLE;
          else         beat_q  <= 1'b1;
        end
        ST_TAIL: begin
          pdata_q <= word_q ? {hi_q, mem_rdata} : {{DW{1'b0}}, mem_rdata};
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
  import stk_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] RESET_SP = 16'h00FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stk_mode,
  input  logic            ld_en,
  input  logic [AW-1:0]   ld_val,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_pop,
  input  logic            req_word,
  input  logic [2*DW-1:0] req_data,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] pop_data,
  output logic [AW-1:0]   sp,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);
  logic          accept;
  logic          load;
  logic          commit;
  logic [AW-1:0] commit_sp;
  logic [AW-1:0] first_addr;
  logic [AW-1:0] next_sp;

  assign req_ready = !busy && !ld_en;
  assign accept    = req_valid && req_ready;
  assign load      = ld_en && !busy;

  stk_addr_calc #(.AW(AW)) u_calc (
    .conv      (stk_mode),
    .pop       (req_pop),
    .word      (req_word),
    .sp_cur    (sp),
    .first_addr(first_addr),
    .next_sp   (next_sp)
  );

  stk_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_pop (req_pop),
    .start_word(req_word),
    .start_data(req_data),
    .start_addr(first_addr),
    .start_nsp (next_sp),
    .busy      (busy),
    .done      (done),
    .commit    (commit),
    .commit_sp (commit_sp),
    .pop_data  (pop_data),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  stk_sp_reg #(.AW(AW), .RESET_SP(RESET_SP)) u_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_val  (ld_val),
    .commit    (commit),
    .commit_val(commit_sp),
    .sp_q      (sp)
  );
endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_en,
  input logic [AW-1:0] ld_val,
  input logic          req_valid,
  input logic          req_ready,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] sp,
  input logic          mem_we,
  input logic          mem_re
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !busy) |=> (sp == $past(ld_val)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_sp_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> (done || $past(ld_en && !busy)));

  p_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_take_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || mem_re));
endmodule

bind stkptr_unit stk_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_en    (ld_en),
  .ld_val   (ld_val),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .busy     (busy),
  .done     (done),
  .sp       (sp),
  .mem_we   (mem_we),
  .mem_re   (mem_re)
);

// File: tb/stkptr_unit_tb_top.sv
module stkptr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stk_mode = 1'b0;
  logic        ld_en = 1'b0;
  logic [15:0] ld_val = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_pop = 1'b0;
  logic        req_word = 1'b0;
  logic [15:0] req_data = '0;
  logic        busy, done;
  logic [15:0] pop_data, sp, mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stkptr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .stk_mode(stk_mode), .ld_en(ld_en), .ld_val(ld_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_pop(req_pop), .req_word(req_word),
    .req_data(req_data), .busy(busy), .done(done), .pop_data(pop_data), .sp(sp),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // byte memory model, indexed by the low address byte
  logic [7:0] bmem [256];
  logic       seed_en = 1'b0;
  logic [7:0] seed_idx = '0;
  logic [7:0] seed_val = '0;
  always @(posedge clk) begin
    if (seed_en) bmem[seed_idx] <= seed_val;
    if (mem_we)  bmem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re)  mem_rdata <= bmem[mem_addr[7:0]];
  end

  typedef struct packed {
    logic        lu;
    logic        pop;
    logic        word;
    logic [15:0] data;
    logic [15:0] sp0;
    logic [15:0] a0;
    logic [15:0] a1;
    logic [15:0] sp1;
    logic [1:0]  lat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,16'h00A5,16'h0100,16'h0100,16'h0000,16'h00FF,2'd1,4'd3},  // R3
    '{1'b0,1'b0,1'b1,16'h1234,16'h0100,16'h00FF,16'h0100,16'h00FE,2'd2,4'd4},  // R4
    '{1'b0,1'b1,1'b0,16'h0000,16'h00FE,16'h00FF,16'h0000,16'h00FF,2'd2,4'd5},  // R5
    '{1'b0,1'b1,1'b1,16'h0000,16'h00FE,16'h00FF,16'h0100,16'h0100,2'd3,4'd5},  // R5
    '{1'b1,1'b0,1'b0,16'h005A,16'h0200,16'h01FF,16'h0000,16'h01FF,2'd1,4'd6},  // R6
    '{1'b1,1'b0,1'b1,16'hBEEF,16'h0200,16'h01FE,16'h01FF,16'h01FE,2'd2,4'd6},  // R6
    '{1'b1,1'b1,1'b0,16'h0000,16'h01FE,16'h01FE,16'h0000,16'h01FF,2'd2,4'd7},  // R7
    '{1'b1,1'b1,1'b1,16'h0000,16'h01FE,16'h01FE,16'h01FF,16'h0200,2'd3,4'd7},  // R7
    '{1'b0,1'b0,1'b1,16'h6789,16'h0000,16'hFFFF,16'h0000,16'hFFFE,2'd2,4'd10}, // R10
    '{1'b1,1'b1,1'b1,16'h0000,16'hFFFF,16'hFFFF,16'h0000,16'h0001,2'd3,4'd10}, // R10
    '{1'b0,1'b1,1'b0,16'h0000,16'hFFFF,16'h0000,16'h0000,16'h0000,2'd2,4'd10}, // R10
    '{1'b1,1'b0,1'b0,16'h00C3,16'h0000,16'hFFFF,16'h0000,16'hFFFF,2'd1,4'd10}  // R10
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic load_sp(input logic [15:0] v);
    @(negedge clk); ld_en = 1'b1; ld_val = v;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic seed(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk); seed_en = 1'b1; seed_idx = idx; seed_val = val;
    @(negedge clk); seed_en = 1'b0;
  endtask

  // Issue one request; report latency, access count, first two addresses, misuse.
  task automatic do_op(input logic lu, input logic pop, input logic word,
                       input logic [15:0] data, input logic flip,
                       output int lat, output int nacc,
                       output logic [15:0] ad0, output logic [15:0] ad1,
                       output logic bad_dir);
    @(negedge clk);
    stk_mode = lu; req_valid = 1'b1; req_pop = pop; req_word = word; req_data = data;
    check(req_ready === 1'b1, "R9", "ready when idle", {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) stk_mode = ~lu;
    lat = 0; nacc = 0; ad0 = '0; ad1 = '0; bad_dir = 1'b0;
    while (!done && lat < 8) begin
      if (mem_we || mem_re) begin
        if (nacc == 0) ad0 = mem_addr;
        if (nacc == 1) ad1 = mem_addr;
        nacc++;
        if ((mem_we && mem_re) || (mem_we && pop) || (mem_re && !pop)) bad_dir = 1'b1;
      end
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : main
    int lat, nacc;
    logic [15:0] ad0, ad1, exp_pd;
    logic bad_dir;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sp == 16'h00FF, "R1", "sp after reset", {16'd0, sp}, 32'h00FF);
    check(!busy && !done, "R1", "busy/done after reset", {30'd0, busy, done}, 32'd0);
    check(!mem_we && !mem_re, "R1", "mem strobes after reset", {30'd0, mem_we, mem_re}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      load_sp(VECS[i].sp0);
      if (VECS[i].pop) begin
        seed(VECS[i].a0[7:0], 8'hC0 + 8'(i));
        if (VECS[i].word) seed(VECS[i].a1[7:0], 8'h30 + 8'(i));
      end
      do_op(VECS[i].lu, VECS[i].pop, VECS[i].word, VECS[i].data, 1'b0,
            lat, nacc, ad0, ad1, bad_dir);
      check(lat == int'(VECS[i].lat), $sformatf("R8 (vec %0d)", i), "done latency",
            lat, {30'd0, VECS[i].lat});
      check(sp == VECS[i].sp1, $sformatf("R%0d (vec %0d)", VECS[i].req, i), "new sp",
            {16'd0, sp}, {16'd0, VECS[i].sp1});
      check(nacc == (VECS[i].word ? 2 : 1) && !bad_dir, $sformatf("R11 (vec %0d)", i),
            "access count/dir", nacc, VECS[i].word ? 2 : 1);
      check(ad0 == VECS[i].a0, $sformatf("R%0d (vec %0d)", VECS[i].req, i), "first addr",
            {16'd0, ad0}, {16'd0, VECS[i].a0});
      if (VECS[i].word)
        check(ad1 == VECS[i].a1, $sformatf("R%0d (vec %0d)", VECS[i].req, i), "second addr",
              {16'd0, ad1}, {16'd0, VECS[i].a1});
      if (VECS[i].pop) begin
        exp_pd = VECS[i].word ? {8'hC0 + 8'(i), 8'h30 + 8'(i)} : {8'h00, 8'hC0 + 8'(i)};
        check(pop_data == exp_pd, $sformatf("R%0d (vec %0d)", VECS[i].req, i), "pop data",
              {16'd0, pop_data}, {16'd0, exp_pd});
      end else if (VECS[i].word) begin
        check(bmem[VECS[i].a0[7:0]] == VECS[i].data[15:8], $sformatf("R%0d (vec %0d)", VECS[i].req, i),
              "high byte in memory", {24'd0, bmem[VECS[i].a0[7:0]]}, {24'd0, VECS[i].data[15:8]});
        check(bmem[VECS[i].a1[7:0]] == VECS[i].data[7:0], $sformatf("R%0d (vec %0d)", VECS[i].req, i),
              "low byte in memory", {24'd0, bmem[VECS[i].a1[7:0]]}, {24'd0, VECS[i].data[7:0]});
      end else begin
        check(bmem[VECS[i].a0[7:0]] == VECS[i].data[7:0], $sformatf("R%0d (vec %0d)", VECS[i].req, i),
              "byte in memory", {24'd0, bmem[VECS[i].a0[7:0]]}, {24'd0, VECS[i].data[7:0]});
      end
      @(negedge clk);
      check(!done, "R8", "done is one cycle", {31'd0, done}, 32'd0);
    end

    // R2: load beats a simultaneous request
    @(negedge clk);
    ld_en = 1'b1; ld_val = 16'hABCD;
    req_valid = 1'b1; req_pop = 1'b0; req_word = 1'b0; req_data = 16'h00EE;
    #1;
    check(req_ready == 1'b0, "R2", "ready low during load", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    ld_en = 1'b0; req_valid = 1'b0;
    check(sp == 16'hABCD, "R2", "sp loaded", {16'd0, sp}, 32'hABCD);
    check(!busy, "R2", "request with load not taken", {31'd0, busy}, 32'd0);

    // R9: requests and loads while busy are ignored
    stk_mode = 1'b0;
    load_sp(16'h0040);
    seed(8'h40, 8'h00);
    seed(8'h41, 8'h11);
    seed(8'h42, 8'h22);
    @(negedge clk);
    req_valid = 1'b1; req_pop = 1'b1; req_word = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_pop = 1'b0; req_word = 1'b0; req_data = 16'h0077;
    ld_en = 1'b1; ld_val = 16'h1234;
    #1;
    check(busy && !req_ready, "R9", "busy, not ready", {30'd0, busy, req_ready}, 32'd2);
    @(negedge clk);
    check(busy && !req_ready, "R9", "still busy", {30'd0, busy, req_ready}, 32'd2);
    @(negedge clk);
    req_valid = 1'b0; ld_en = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R9", "first op completes", {31'd0, done}, 32'd1);
    check(pop_data == 16'h1122, "R9", "pop data of taken op", {16'd0, pop_data}, 32'h1122);
    check(sp == 16'h0042, "R9", "sp of taken op", {16'd0, sp}, 32'h0042);
    repeat (2) @(negedge clk);
    check(sp == 16'h0042, "R9", "ignored load left sp", {16'd0, sp}, 32'h0042);
    check(bmem[8'h40] == 8'h00, "R9", "ignored push left memory", {24'd0, bmem[8'h40]}, 32'h0);

    // R11: mode sampled at acceptance (occupied-slot word push, mode flips after)
    load_sp(16'h0300);
    do_op(1'b1, 1'b0, 1'b1, 16'hCAFE, 1'b1, lat, nacc, ad0, ad1, bad_dir);
    check(ad0 == 16'h02FE && ad1 == 16'h02FF, "R11", "addresses after mode flip",
          {ad0, ad1}, 32'h02FE02FF);
    check(sp == 16'h02FE, "R11", "sp after mode flip", {16'd0, sp}, 32'h02FE);
    check(bmem[8'hFE] == 8'hCA && bmem[8'hFF] == 8'hFE, "R11", "bytes after mode flip",
          {16'd0, bmem[8'hFE], bmem[8'hFF]}, 32'hCAFE);

    summary();
  end
endmodule